// File: doc/BRIEF.md
# Oversampled Serial Frame Receiver

This block takes an asynchronous serial line carrying frames of one start bit, eight data bits (least significant first) and one stop bit, and turns each good frame into a 32-bit word. A clock enable supplied from outside pulses eight times per bit period. The line goes through a two-flop synchronizer. The receiver then waits for a low level on an enable tick and takes a single sample in the middle of each data bit. It checks the stop bit before it hands the word on.

A good frame's byte is left-justified in the word: bits 31:24 hold the byte and the low 24 bits are zero. Words go into an eight-entry FIFO that a reader drains through a valid/ready port. Back-pressure follows these rules:
- `out_valid` stays high and `out_data` stays unchanged until the reader takes the word with `out_ready`.
- When the FIFO is full, the receiver holds the finished word and waits. It never overwrites an entry.

A frame whose stop bit reads low is dropped and `frame_err` pulses for one clock. The receiver then waits for the line to return high before it looks for the next start bit.

Top module: `osrx_receiver`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties the FIFO and returns the receiver to idle. After the edge, `out_valid` and `frame_err` are 0.
- R2: A start is detected on an enable tick where the synchronized line is 0. The first data bit is sampled 12 ticks later, and each further data bit or stop bit is sampled 8 ticks after the previous sample. No word can appear before the stop bit has started.
- R3: Eight data bits are taken least significant bit first and enter at bit 31 of a right-shifting register. A pushed word equals the byte shifted left by 24, with bits 23:0 zero.
- R4: When the stop bit samples 1, exactly one word is pushed into the FIFO and `frame_err` stays 0.
- R5: When the stop bit samples 0, no word is pushed and `frame_err` is high for exactly one clock cycle.
- R6: After a framing error the receiver ignores a line that stays low and only rearms once the line has read high. A frame sent after that is received correctly.
- R7: The FIFO holds 8 words in arrival order. If a word is ready while the FIFO is full, the receiver stalls with that word and pushes it once space frees, with nothing lost or overwritten.
- R8: A word is taken when `out_valid` and `out_ready` are both high at a clock edge. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` is stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Oversampling enable, 8 pulses per bit period |
| rx_line | input | 1 | Asynchronous serial input, idles high |
| out_valid | output | 1 | FIFO holds at least one word |
| out_ready | input | 1 | Reader accepts the word at the head |
| out_data | output | 32 | Head word, received byte in bits 31:24 |
| frame_err | output | 1 | One-cycle pulse on a low stop bit |

## Verification
The bench sends bytes whose bit order exposes a reversed shift or a wrong justification (0x01, 0x80, 0x55, 0xA5, all zeros, all ones). A receiver that shifted the wrong way or packed the byte low would return a different word. The framing-error case keeps the line low for three bit periods after the bad stop bit. A receiver that rearmed at once would frame that low level again and raise further error pulses. The back-pressure case queues nine frames with the reader stalled. A FIFO that overwrote entries, or a receiver that dropped the ninth word, would return fewer or out-of-order words. A check in the middle of each frame catches a stop bit sampled too early.

// File: rtl/osrx_pkg.sv
package osrx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_SHIFT,
    RX_STOP,
    RX_PUSH,
    RX_HOLD
  } rx_state_e;
endpackage

// File: rtl/osrx_sync.sv
module osrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b1;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/osrx_framer.sv
module osrx_framer
  import osrx_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int DATA_BITS = 8,
  parameter int TICKS     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              rx_s,
  output logic              push_valid,
  input  logic              push_ready,
  output logic [WORD_W-1:0] push_data,
  output logic              err_pulse
);
  localparam int FIRST = TICKS + TICKS / 2;
  localparam int CNT_W = $clog2(FIRST + 1);
  localparam int BIT_W = $clog2(DATA_BITS + 1);

  rx_state_e         state;
  logic [CNT_W-1:0]  tick_cnt;
  logic [BIT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] shreg;
  logic              err_q;
  logic              sample_now;

  assign sample_now = tick_en && (tick_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_IDLE;
      tick_cnt <= '0;
      bit_cnt  <= '0;
      shreg    <= '0;
      err_q    <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state)
        RX_IDLE: begin
          if (tick_en && !rx_s) begin
            tick_cnt <= CNT_W'(FIRST - 1);
            bit_cnt  <= '0;
            shreg    <= '0;
            state    <= RX_SHIFT;
          end
        end
        RX_SHIFT: begin
          if (sample_now) begin
            shreg    <= {rx_s, shreg[WORD_W-1:1]};
            tick_cnt <= CNT_W'(TICKS - 1);
            if (bit_cnt == BIT_W'(DATA_BITS - 1)) state <= RX_STOP;
            else bit_cnt <= bit_cnt + 1'b1;
          end else if (tick_en) begin
            tick_cnt <= tick_cnt - 1'b1;
          end
        end
        RX_STOP: begin
          if (sample_now) begin
            if (rx_s) begin
              state <= RX_PUSH;
            end else begin
              err_q <= 1'b1;
              state <= RX_HOLD;
            end
          end else if (tick_en) begin
            tick_cnt <= tick_cnt - 1'b1;
          end
        end
        RX_PUSH: begin
          if (push_ready) state <= RX_IDLE;
        end
        RX_HOLD: begin
          if (rx_s) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign push_valid = (state == RX_PUSH);
  assign push_data  = shreg;
  assign err_pulse  = err_q;
endmodule

// File: rtl/osrx_fifo.sv
module osrx_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wr_ptr;
  logic [AW:0]      rd_ptr;
  logic             full;
  logic             empty;
  logic             do_push;
  logic             do_pop;

  assign empty    = (wr_ptr == rd_ptr);
  assign full     = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign in_ready = !full;
  assign do_push  = in_valid && !full;
  assign do_pop   = !empty && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr[AW-1:0]] <= in_data;
  end

  assign out_valid = !empty;
  assign out_data  = mem[rd_ptr[AW-1:0]];
endmodule

// File: rtl/osrx_receiver.sv
module osrx_receiver #(
  parameter int WORD_W     = 32,
  parameter int DATA_BITS  = 8,
  parameter int TICKS      = 8,
  parameter int FIFO_DEPTH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              rx_line,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              frame_err
);
  logic              rx_s;
  logic              push_valid;
  logic              push_ready;
  logic [WORD_W-1:0] push_data;

  osrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (rx_line),
    .sync_out (rx_s)
  );

  osrx_framer #(
    .WORD_W    (WORD_W),
    .DATA_BITS (DATA_BITS),
    .TICKS     (TICKS)
  ) u_framer (
    .clk        (clk),
    .rst        (rst),
    .tick_en    (tick_en),
    .rx_s       (rx_s),
    .push_valid (push_valid),
    .push_ready (push_ready),
    .push_data  (push_data),
    .err_pulse  (frame_err)
  );

  osrx_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (push_valid),
    .in_ready  (push_ready),
    .in_data   (push_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );
endmodule

// File: rtl/osrx_checks.sv
module osrx_checks #(
  parameter int WORD_W    = 32,
  parameter int DATA_BITS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              frame_err,
  input logic              push_valid,
  input logic              push_ready,
  input logic [WORD_W-1:0] push_data
);
  p_reset_empty_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && !frame_err));

  p_low_bits_zero_r3: assert property (@(posedge clk) disable iff (rst)
    push_valid |-> (push_data[WORD_W-DATA_BITS-1:0] == '0));

  p_err_single_r5: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> !frame_err);

  p_err_no_push_r5: assert property (@(posedge clk) disable iff (rst)
    frame_err |-> !push_valid);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    (push_valid && !push_ready) |=> (push_valid && $stable(push_data)));

  p_hold_head_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind osrx_receiver osrx_checks #(.WORD_W(WORD_W), .DATA_BITS(DATA_BITS)) u_checks (
  .clk        (clk),
  .rst        (rst),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .frame_err  (frame_err),
  .push_valid (push_valid),
  .push_ready (push_ready),
  .push_data  (push_data)
);

// File: tb/osrx_receiver_test.sv
module osrx_receiver_test;
  localparam int CLK_P    = 10;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLKS = 8 * TICK_DIV;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        rx_line = 1'b1;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic        frame_err;

  int n_tests = 0;
  int n_fail  = 0;
  int err_cnt = 0;
  bit done    = 1'b0;

  osrx_receiver uut (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .rx_line   (rx_line),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .frame_err (frame_err)
  );

  always #(CLK_P/2) clk = ~clk;

  initial begin
    int phase = 0;
    forever begin
      @(negedge clk);
      tick_en = (phase == 0);
      phase = (phase + 1) % TICK_DIV;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst && frame_err) err_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_bits(input int nbits);
    repeat (nbits * BIT_CLKS) @(negedge clk);
  endtask

  // Start bit, 8 data bits LSB first, stop bit, then one idle bit.
  task automatic send_frame(input logic [7:0] b, input bit check_early);
    rx_line = 1'b0;
    wait_bits(1);
    for (int i = 0; i < 8; i++) begin
      rx_line = b[i];
      wait_bits(1);
    end
    if (check_early)
      check(out_valid == 1'b0, "R2", {31'd0, out_valid}, 32'd0);
    rx_line = 1'b1;
    wait_bits(2);
  endtask

  task automatic pop_expect(input logic [31:0] exp, input string req);
    int waited = 0;
    while (!out_valid && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    check(out_valid && out_data == exp, req, out_data, exp);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_reset;
    check(out_valid == 1'b0, "R1", {31'd0, out_valid}, 32'd0);
    check(frame_err == 1'b0, "R1", {31'd0, frame_err}, 32'd0);
  endtask

  task automatic t_good_frames;
    logic [7:0] vals [7] = '{8'h55, 8'hA5, 8'h00, 8'hFF, 8'h01, 8'h80, 8'h3C};
    int e0 = err_cnt;
    foreach (vals[k]) begin
      send_frame(vals[k], 1'b1);
      pop_expect({vals[k], 24'd0}, "R3");
    end
    check(err_cnt == e0, "R4", err_cnt, e0);
    check(out_valid == 1'b0, "R4", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_frame_error;
    logic [7:0] b = 8'h5A;
    int e0 = err_cnt;
    rx_line = 1'b0;
    wait_bits(1);
    for (int i = 0; i < 8; i++) begin
      rx_line = b[i];
      wait_bits(1);
    end
    rx_line = 1'b0;
    wait_bits(4);
    check(err_cnt - e0 == 1, "R5", err_cnt - e0, 1);
    check(out_valid == 1'b0, "R5", {31'd0, out_valid}, 32'd0);
    rx_line = 1'b1;
    wait_bits(2);
    check(err_cnt - e0 == 1, "R6", err_cnt - e0, 1);
    send_frame(8'hC3, 1'b0);
    pop_expect({8'hC3, 24'd0}, "R6");
  endtask

  task automatic t_backpressure;
    logic [31:0] head;
    out_ready = 1'b0;
    for (int i = 0; i < 9; i++) send_frame(8'(i * 17 + 1), 1'b0);
    check(out_valid == 1'b1 && out_data == 32'h0100_0000, "R8", out_data, 32'h0100_0000);
    head = out_data;
    wait_bits(1);
    check(out_valid == 1'b1 && out_data == head, "R8", out_data, head);
    for (int i = 0; i < 9; i++) pop_expect({8'(i * 17 + 1), 24'd0}, "R7");
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R7", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_reset_mid;
    send_frame(8'h77, 1'b0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R1", {31'd0, out_valid}, 32'd0);
    rst = 1'b0;
    send_frame(8'h99, 1'b0);
    pop_expect({8'h99, 24'd0}, "R1");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset;
    rst = 1'b0;
    repeat (4) @(negedge clk);
    t_good_frames;
    t_frame_error;
    t_backpressure;
    t_reset_mid;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule